// File: doc/BRIEF.md
# Flash Status-Bit Completion Checker

This block runs on the host side of a flash memory. Once a program or erase operation has been launched, it decides whether that operation finished well. It does this by repeatedly reading one byte from the device. On each read it compares bit 7 against bit 7 of the value the operation should leave behind. For an erase that value is 0xFF. Bit 5 is the device's time-limit flag. When bit 5 is found set, the block makes one confirming read before it declares a failure, because bit 7 and bit 5 may flip in the same device cycle.

A single-cycle `start` strobe hands the block the polling address and the expected byte. The block latches both and then reads only from that address. Reads go through a simple request/acknowledge port. Once bit 7 matches, the block makes one more read to pick up a byte whose low bits are also settled, since bits 6..0 may still be stale on the read where bit 7 first matches. It then raises `done` for one cycle, with `pass` and `result_byte` held until the next accepted start. A parameter caps the number of plain mismatching reads, so a device that never answers cannot hang the block.

Top module: `poll_checker`

## Requirements
- R1: Every read request carries the address latched at the accepted start. A read completes on a cycle where `rd_req` and `rd_ack` are both high, and `rd_data` is sampled on that cycle.
- R2: When a polling read returns bit 7 equal to bit 7 of the expected byte, the block issues exactly one more read. It captures that byte on `result_byte` and finishes with `pass` = 1.
- R3: When a polling read returns bit 7 unequal to the expected bit 7 and bit 5 = 0, the block issues another polling read.
- R4: When a polling read returns a bit 7 mismatch with bit 5 = 1, the block issues one confirming read. If that read's bit 7 matches, the flow continues as in R2. If it mismatches, the block finishes with `pass` = 0, and `result_byte` holds the confirming read's byte.
- R5: After MAX_POLLS polling reads that all return a bit 7 mismatch with bit 5 = 0, the block finishes with `pass` = 0, and `result_byte` holds the last byte read.
- R6: `done` is high for exactly one cycle per accepted start. `pass` and `result_byte` stay unchanged from that pulse until the next accepted start.
- R7: A `start` that arrives while `busy` is high is ignored. The running sequence keeps its address, its expected bit and its read count.
- R8: After reset, `busy`, `rd_req`, `done` and `pass` are all 0.
- R9: Once raised, `rd_req` stays high with a stable address until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a check (taken only when idle) |
| poll_addr | input | ADDR_W | Address to poll |
| expect_byte | input | 8 | Byte the operation should leave (0xFF for erase) |
| rd_req | output | 1 | Read request |
| rd_addr | output | ADDR_W | Read address |
| rd_ack | input | 1 | Read acknowledge; data valid this cycle |
| rd_data | input | 8 | Read data |
| busy | output | 1 | Check in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Result of the last check |
| result_byte | output | 8 | Final byte read by the last check |

## Verification
The embedded properties check, on every cycle, that a request is held until it is acknowledged and that the read address never moves during a check. They also check that `done` lasts one cycle and only when idle, that an idle start always leads to a request on the next cycle, that results stay frozen while idle, and that the poll counter stays within its limit. The decision path can only be shown by the bench's scenarios. Those scenarios sweep every mismatch count up to and beyond the limit, the direct match, the flagged-then-match and flagged-then-mismatch endings, both polarities of the expected bit, and several acknowledge latencies. In each case they compare the outcome, the captured byte and the exact number of reads against values computed from the scenario.

// File: rtl/poll_checker.sv
module poll_checker #(
  parameter int ADDR_W    = 20,
  parameter int MAX_POLLS = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] poll_addr,
  input  logic [7:0]        expect_byte,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ack,
  input  logic [7:0]        rd_data,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic [7:0]        result_byte
);
  localparam int CW = $clog2(MAX_POLLS + 1);
  localparam logic [CW-1:0] LAST_POLL = CW'(MAX_POLLS - 1);

  typedef enum logic [1:0] {S_IDLE, S_POLL, S_RECHK, S_FINAL} state_t;

  state_t            st;
  logic [ADDR_W-1:0] addr_q;
  logic              want7;
  logic [CW-1:0]     polls;
  logic              done_q, pass_q;
  logic [7:0]        data_q;

  wire xfer = rd_req & rd_ack;
  wire hit  = rd_data[7] == want7;

  assign busy        = st != S_IDLE;
  assign rd_req      = busy;
  assign rd_addr     = addr_q;
  assign done        = done_q;
  assign pass        = pass_q;
  assign result_byte = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      addr_q <= '0;
      want7  <= 1'b0;
      polls  <= '0;
      done_q <= 1'b0;
      pass_q <= 1'b0;
      data_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (xfer) data_q <= rd_data;
      case (st)
        S_IDLE: if (start) begin
          addr_q <= poll_addr;
          want7  <= expect_byte[7];
          polls  <= '0;
          pass_q <= 1'b0;
          st     <= S_POLL;
        end
        S_POLL: if (xfer) begin
          if (hit) st <= S_FINAL;
          else if (rd_data[5]) st <= S_RECHK;
          else if (polls == LAST_POLL) begin
            done_q <= 1'b1;
            st     <= S_IDLE;
          end else polls <= polls + 1'b1;
        end
        S_RECHK: if (xfer) begin
          if (hit) st <= S_FINAL;
          else begin
            done_q <= 1'b1;
            st     <= S_IDLE;
          end
        end
        S_FINAL: if (xfer) begin
          pass_q <= 1'b1;
          done_q <= 1'b1;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ack |=> rd_req && $stable(rd_addr));
  // R1
  addr_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(rd_addr));
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> $stable(pass) && $stable(result_byte));
  // R7
  start_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start |=> rd_req && !done);
  // R5
  poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    polls < CW'(MAX_POLLS));
endmodule

// File: tb/poll_checker_test.sv
module poll_checker_test;
  localparam int AW = 12;
  localparam int MAXP = 5;

  logic clk = 0, rst_n = 0, start = 0, rd_ack = 0;
  logic [AW-1:0] poll_addr = '0;
  logic [7:0] expect_byte = '0, rd_data = '0;
  logic rd_req, busy, done, pass;
  logic [AW-1:0] rd_addr;
  logic [7:0] result_byte;

  int checks = 0, fails = 0, cyc = 0;
  int nreads = 0, wcnt = 0, lat = 0, addr_bad = 0;
  logic [AW-1:0] cur_addr = '0;
  logic [7:0] resp [0:15];

  poll_checker #(.ADDR_W(AW), .MAX_POLLS(MAXP)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .poll_addr(poll_addr),
    .expect_byte(expect_byte), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_ack(rd_ack), .rd_data(rd_data), .busy(busy), .done(done),
    .pass(pass), .result_byte(result_byte));

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  // memory responder
  initial begin
    forever begin
      @(negedge clk);
      if (rd_ack) begin
        nreads++;
        rd_ack = 0;
      end
      if (rd_req) begin
        if (wcnt >= lat) begin
          rd_ack = 1;
          rd_data = resp[nreads];
          if (rd_addr != cur_addr) addr_bad++;
          wcnt = 0;
        end else wcnt++;
      end
    end
  end

  task automatic run(input int t, input int k, input logic [7:0] e, input int l);
    logic e7, got_pass;
    logic [7:0] fin, exp_final, got_final;
    int exp_reads, seen;
    bit exp_pass;
    e7 = e[7];
    fin = {e7, 7'(k * 3 + t + 1)};
    for (int i = 0; i < 16; i++) resp[i] = {~e7, 2'b00, 5'(i)};
    if (k >= MAXP) begin
      exp_reads = MAXP; exp_pass = 0; exp_final = {~e7, 2'b00, 5'(MAXP - 1)};
    end else if (t == 0) begin
      resp[k] = {e7, 7'h55}; resp[k+1] = fin;
      exp_reads = k + 2; exp_pass = 1; exp_final = fin;
    end else if (t == 1) begin
      resp[k] = {~e7, 7'h3F}; resp[k+1] = {e7, 7'h2A}; resp[k+2] = fin;
      exp_reads = k + 3; exp_pass = 1; exp_final = fin;
    end else begin
      resp[k] = {~e7, 7'h3F}; resp[k+1] = {~e7, 7'h11};
      exp_reads = k + 2; exp_pass = 0; exp_final = {~e7, 7'h11};
    end
    @(negedge clk);
    lat = l; nreads = 0; wcnt = 0; addr_bad = 0;
    cur_addr = AW'(k * 37 + t * 5 + l + 1);
    poll_addr = cur_addr; expect_byte = e; start = 1;
    @(negedge clk);
    poll_addr = ~cur_addr; expect_byte = ~e;   // R7 stray start while busy
    @(negedge clk);
    start = 0;
    seen = 0;
    for (int i = 0; i < 300 && !seen; i++) begin
      if (done) seen = 1; else @(negedge clk);
    end
    chk(seen == 1, "R6 done seen", seen, 1);
    got_pass = pass; got_final = result_byte;
    if (exp_pass) chk(pass == 1, "R2/R4 pass", pass, 1);
    else chk(pass == 0, (k >= MAXP) ? "R5 limit fail" : "R4 flagged fail", pass, 0);
    chk(result_byte == exp_final, (k >= MAXP) ? "R5 result" : "R2 result_byte", result_byte, exp_final);
    @(negedge clk);
    chk(done == 0, "R6 done one cycle", done, 0);
    chk(busy == 0, "R6 idle after done", busy, 0);
    @(negedge clk); @(negedge clk);
    chk(pass == got_pass && result_byte == got_final, "R6 hold", {pass, result_byte}, {got_pass, got_final});
    chk(nreads == exp_reads, (k > 0) ? "R3 read count" : "R7 read count", nreads, exp_reads);
    chk(addr_bad == 0, "R1 R7 address", addr_bad, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && rd_req == 0, "R8 reset idle", {busy, rd_req}, 0);
    chk(done == 0 && pass == 0, "R8 reset outputs", {done, pass}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0 && rd_req == 0 && done == 0, "R8 after reset", {busy, rd_req, done}, 0);
    for (int l = 0; l < 3; l++)
      for (int ei = 0; ei < 2; ei++)
        for (int t = 0; t < 3; t++)
          for (int k = 0; k <= MAXP; k++)
            run(t, k, ei ? 8'hFF : 8'h3C, l);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule